// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous request stream and an external 16-bit asynchronous static RAM of 262,144 words. It takes one single-beat read or write at a time. For each one it produces address, chip-select, output-enable, write-enable and per-byte-lane select strobes. Every phase is held for at least the number of clock cycles that the configured nanosecond minimums require at the configured clock frequency. The data bus leaves the block as three separate signals: an output value, a drive enable and an input value. A pad ring or a bench model resolves them.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle. A request transfers on the rising edge where both `req_valid` and `req_ready` are high. The requester may hold `req_valid` high for any length of time, and nothing is lost while `req_ready` is low. All request fields are captured at the transfer edge. Read data comes back on `rsp_rdata`, marked by a one-cycle `rsp_valid` pulse. There is no back-pressure on the response side.

A level input, `standby_req`, puts the memory into its retention state. It takes effect only between accesses. When it is released, a recovery interval of one read-cycle time runs before the next access is taken.

Top module: `sram_ctl`

## Requirements
- R1: `req_ready` is high only in the idle state. It is low in the cycle after a transfer, and low throughout every access, standby and wake interval.
- R2: The memory is selected (`sram_ce_n` low and `sram_ce` high) only during a read or write. At all other times `sram_ce_n` is high and `sram_ce` is low. Write enable falls only while the memory is selected.
- R3: Write enable stays low for at least max(ceil(t·f)) cycles over the write-pulse (55 ns), select-to-end (60 ns), byte-select-to-end (60 ns) and data-setup (30 ns) minimums, with t in ns and f in GHz, and never less than 1 cycle.
- R4: Output enable stays high for the whole of every write. The controller drives the bus (`dq_oe`=1) from one setup cycle before write enable falls until the clock edge at which write enable rises.
- R5: `req_be[0]`=1 enables the lower lane (bits 7..0, `sram_bs_n[0]` low). `req_be[1]`=1 enables the upper lane (bits 15..8, `sram_bs_n[1]` low). Only enabled lanes are written. A write with `req_be`=00 leaves memory unchanged.
- R6: A read holds select, output enable and the lane selects for at least max(ceil 70 ns, ceil 35 ns, ceil 70 ns) cycles before sampling. It then returns the data with a single-cycle `rsp_valid`. Disabled lanes read as zero.
- R7: The controller never drives the bus while output enable is low. After a read it waits at least ceil(25 ns) cycles after output enable rises before it drives again.
- R8: Each write keeps the memory selected for at least ceil(70 ns) cycles.
- R9: When idle with `standby_req` high and no valid request, the controller enters standby. In standby `req_ready` is low and the memory is deselected. A valid request offered in the same cycle as `standby_req` is served first.
- R10: After `standby_req` falls, `req_ready` stays low for exactly ceil(70 ns) cycles before returning high.
- R11: After reset, `req_ready` is high and the memory is deselected. Write enable and output enable are high, `dq_oe` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 lower, bit 1 upper |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| standby_req | input | 1 | Request retention standby |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_ce | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_bs_n | output | 2 | Active-low lane selects, bit 0 lower |
| dq_out | output | 16 | Bus value to drive |
| dq_oe | output | 1 | Bus drive enable |
| dq_in | input | 16 | Bus value sampled |

## Verification
The hardest situation to reach is a write that follows a read straight away. That is the only place the bus turnaround rule can fail. It takes a read followed by a write with `req_valid` already waiting when `req_ready` returns. The random phase issues back-to-back mixed requests with no idle gap to create this case many times. A bench memory model counts the cycles between output enable rising and the first drive. The same model only returns true data once the read strobes have been held for the access time, so sampling too early shows up as a wrong read-back value. Standby entry that coincides with a request is set up directly, on a single edge.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_RD_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_STANDBY,
    ST_WAKE
  } state_e;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned L_RD   = 7,
  parameter int unsigned L_TURN = 3,
  parameter int unsigned L_AS   = 1,
  parameter int unsigned L_WP   = 6,
  parameter int unsigned L_WR   = 1,
  parameter int unsigned L_WAKE = 7,
  parameter int unsigned CNT_W  = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_we,
  input  logic   standby_req,
  output logic   accept,
  output logic   idle,
  output state_e state
);

  state_e             state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               last;

  assign last   = (cnt_q == '0);
  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && req_valid;
  assign state  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid)        state_d = req_we ? ST_WR_SETUP : ST_RD_ACCESS;
        else if (standby_req) state_d = ST_STANDBY;
      end
      ST_RD_ACCESS:  if (last) state_d = ST_RD_CAPTURE;
      ST_RD_CAPTURE: state_d = ST_RD_TURN;
      ST_RD_TURN:    if (last) state_d = ST_IDLE;
      ST_WR_SETUP:   if (last) state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (last) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: if (last) state_d = ST_IDLE;
      ST_STANDBY:    if (!standby_req) state_d = ST_WAKE;
      ST_WAKE:       if (last) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // Phase length is loaded on entry and counted down to zero.
  always_comb begin
    if (state_d != state_q) begin
      unique case (state_d)
        ST_RD_ACCESS:  cnt_d = CNT_W'(L_RD - 1);
        ST_RD_TURN:    cnt_d = CNT_W'(L_TURN - 1);
        ST_WR_SETUP:   cnt_d = CNT_W'(L_AS - 1);
        ST_WR_PULSE:   cnt_d = CNT_W'(L_WP - 1);
        ST_WR_RECOVER: cnt_d = CNT_W'(L_WR - 1);
        ST_WAKE:       cnt_d = CNT_W'(L_WAKE - 1);
        default:       cnt_d = '0;
      endcase
    end else begin
      cnt_d = last ? cnt_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_e            state,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [LANES-1:0]  sram_bs_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [LANES-1:0] be_q;
  logic sel, rd_lvl, drive, pulse, capture;

  assign sel     = (state inside {ST_RD_ACCESS, ST_RD_CAPTURE, ST_WR_SETUP,
                                  ST_WR_PULSE, ST_WR_RECOVER});
  assign rd_lvl  = (state inside {ST_RD_ACCESS, ST_RD_CAPTURE});
  assign drive   = (state inside {ST_WR_SETUP, ST_WR_PULSE});
  assign pulse   = (state == ST_WR_PULSE);
  assign capture = (state == ST_RD_CAPTURE);

  // Request fields captured at the transfer edge; held for the whole access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr <= '0;
      dq_out    <= '0;
      be_q      <= '0;
    end else if (accept) begin
      sram_addr <= req_addr;
      dq_out    <= req_wdata;
      be_q      <= req_be;
    end
  end

  // Every strobe comes straight from a flop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n <= 1'b1;
      sram_ce   <= 1'b0;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_bs_n <= '1;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      sram_ce_n <= !sel;
      sram_ce   <= sel;
      sram_oe_n <= !rd_lvl;
      sram_we_n <= !pulse;
      sram_bs_n <= sel ? ~be_q : '1;
      dq_oe     <= drive;
      rsp_valid <= capture;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rsp_rdata[g*8 +: 8] <= '0;
      else if (capture) rsp_rdata[g*8 +: 8] <= be_q[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned T_RC_NS   = 70,
  parameter int unsigned T_AA_NS   = 70,
  parameter int unsigned T_OE_NS   = 35,
  parameter int unsigned T_OHZ_NS  = 25,
  parameter int unsigned T_WC_NS   = 70,
  parameter int unsigned T_WP_NS   = 55,
  parameter int unsigned T_CW_NS   = 60,
  parameter int unsigned T_BW_NS   = 60,
  parameter int unsigned T_AS_NS   = 0,
  parameter int unsigned T_WR_NS   = 0,
  parameter int unsigned T_DS_NS   = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic                standby_req,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic                sram_ce_n,
  output logic                sram_ce,
  output logic                sram_oe_n,
  output logic                sram_we_n,
  output logic [DATA_W/8-1:0] sram_bs_n,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe,
  input  logic [DATA_W-1:0]   dq_in
);

  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned L_RD   = umax(ns2cyc(T_RC_NS, CLK_MHZ),
                                        umax(ns2cyc(T_AA_NS, CLK_MHZ), ns2cyc(T_OE_NS, CLK_MHZ)));
  localparam int unsigned L_TURN = ns2cyc(T_OHZ_NS, CLK_MHZ);
  localparam int unsigned L_AS   = ns2cyc(T_AS_NS, CLK_MHZ);
  localparam int unsigned L_WP   = umax(umax(ns2cyc(T_WP_NS, CLK_MHZ), ns2cyc(T_DS_NS, CLK_MHZ)),
                                        umax(ns2cyc(T_CW_NS, CLK_MHZ), ns2cyc(T_BW_NS, CLK_MHZ)));
  localparam int unsigned L_WC   = ns2cyc(T_WC_NS, CLK_MHZ);
  localparam int unsigned L_WR   = umax(ns2cyc(T_WR_NS, CLK_MHZ),
                                        (L_WC > L_AS + L_WP) ? (L_WC - L_AS - L_WP) : 1);
  localparam int unsigned L_WAKE = ns2cyc(T_RC_NS, CLK_MHZ);
  localparam int unsigned L_MAX  = umax(umax(L_RD, L_TURN), umax(umax(L_AS, L_WP), umax(L_WR, L_WAKE)));
  localparam int unsigned CNT_W  = $clog2(L_MAX) + 1;

  state_e state;
  logic   accept;

  sram_ctl_seq #(
    .L_RD(L_RD), .L_TURN(L_TURN), .L_AS(L_AS), .L_WP(L_WP),
    .L_WR(L_WR), .L_WAKE(L_WAKE), .CNT_W(CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .standby_req (standby_req),
    .accept      (accept),
    .idle        (req_ready),
    .state       (state)
  );

  sram_ctl_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .dq_in     (dq_in),
    .sram_addr (sram_addr),
    .sram_ce_n (sram_ce_n),
    .sram_ce   (sram_ce),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .sram_bs_n (sram_bs_n),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned L_WP   = 6,
  parameter int unsigned L_TURN = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic standby_req,
  input logic rsp_valid,
  input logic sram_ce_n,
  input logic sram_ce,
  input logic sram_oe_n,
  input logic sram_we_n,
  input logic dq_oe
);

  logic [15:0] wp_cnt, ohi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_cnt  <= '0;
      ohi_cnt <= 16'(L_TURN);
    end else begin
      wp_cnt  <= !sram_we_n ? ((wp_cnt == 16'hFFFF) ? wp_cnt : wp_cnt + 1'b1) : '0;
      ohi_cnt <= sram_oe_n ? ((ohi_cnt >= 16'(L_TURN)) ? ohi_cnt : ohi_cnt + 1'b1) : '0;
    end
  end

  p_ready_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_we_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_ce_n && sram_ce));

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (wp_cnt >= 16'(L_WP)));

  p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  p_data_held_to_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> $past(dq_oe));

  p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> sram_oe_n);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (ohi_cnt >= 16'(L_TURN)));

  p_standby_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    standby_req && req_ready && !req_valid |=> !req_ready && sram_ce_n && !sram_ce);

endmodule

bind sram_ctl sram_ctl_chk #(.L_WP(L_WP), .L_TURN(L_TURN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .standby_req (standby_req),
  .rsp_valid   (rsp_valid),
  .sram_ce_n   (sram_ce_n),
  .sram_ce     (sram_ce),
  .sram_oe_n   (sram_oe_n),
  .sram_we_n   (sram_we_n),
  .dq_oe       (dq_oe)
);

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;

  localparam int MHZ = 125;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_we = 0, standby_req = 0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid, sram_ce_n, sram_ce, sram_oe_n, sram_we_n, dq_oe;
  logic [15:0] rsp_rdata, dq_out, dq_in;
  logic [17:0] sram_addr;
  logic [1:0]  sram_bs_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sram_ctl #(.CLK_MHZ(MHZ)) u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .standby_req(standby_req),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_bs_n(sram_bs_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  function automatic int cyc(input int ns);
    int c;
    c = (ns * MHZ + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int exp_wp, exp_rd, exp_turn, exp_wc, exp_wake;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [15:0] mem  [0:1023];
  logic [15:0] refm [0:1023];
  int  wcnt = 0, rcnt = 0, ohc = 100, cecnt = 0;
  bit  prev_we_low = 0, prev_oe_drv = 0, wr_seen = 0;
  logic [15:0] cap_d;
  logic [1:0]  cap_bs;
  logic [9:0]  cap_a;
  logic [17:0] last_addr = '0;
  logic        rd_lvl;

  assign rd_lvl = !sram_ce_n && sram_ce && !sram_oe_n && sram_we_n;
  for (genvar g = 0; g < 2; g++) begin : g_mdl
    assign dq_in[g*8 +: 8] = (rd_lvl && !sram_bs_n[g])
                             ? ((rcnt >= exp_rd) ? mem[sram_addr[9:0]][g*8 +: 8] : 8'hA5)
                             : 8'h00;
  end

  always @(negedge clk) if (rst_n) begin
    if (dq_oe && !sram_oe_n) chk(0, "R7 bus contention", 1, 0);
    if (dq_oe && !prev_oe_drv) chk(ohc >= exp_turn, "R7 turnaround", ohc, exp_turn);
    ohc = sram_oe_n ? ((ohc < 100) ? ohc + 1 : ohc) : 0;
    prev_oe_drv = dq_oe;

    if (!sram_we_n) begin
      wcnt++;
      if (!(sram_oe_n && dq_oe && !sram_ce_n)) chk(0, "R4 write strobes", {sram_oe_n, dq_oe, sram_ce_n}, 3'b110);
      cap_d  = dq_out;
      cap_bs = sram_bs_n;
      cap_a  = sram_addr[9:0];
      prev_we_low = 1;
      wr_seen = 1;
    end else if (prev_we_low) begin
      chk(wcnt >= exp_wp, "R3 write pulse", wcnt, exp_wp);
      if (!cap_bs[0]) mem[cap_a][7:0]  = cap_d[7:0];
      if (!cap_bs[1]) mem[cap_a][15:8] = cap_d[15:8];
      wcnt = 0;
      prev_we_low = 0;
    end

    if (!sram_ce_n && sram_ce) cecnt++;
    else begin
      if (wr_seen) chk(cecnt >= exp_wc, "R8 write cycle", cecnt, exp_wc);
      cecnt = 0;
      wr_seen = 0;
    end

    if (rd_lvl && sram_addr == last_addr) rcnt++;
    else rcnt = rd_lvl ? 1 : 0;
    last_addr = sram_addr;
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

  function automatic logic [15:0] rd_exp(input logic [15:0] v, input logic [1:0] be);
    return {be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic offer(input bit we, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R1 ready after transfer", req_ready, 0);
  endtask

  task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    offer(1, a, d, be);
    refm[a[9:0]] = merge(refm[a[9:0]], d, be);
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be);
    int n;
    logic [15:0] e;
    e = rd_exp(refm[a[9:0]], be);
    offer(0, a, 16'h0, be);
    n = 0;
    while (!rsp_valid && n < 60) begin @(negedge clk); n++; end
    chk(rsp_valid, "R6 response arrives", rsp_valid, 1);
    chk(rsp_rdata === e, "R6 R5 read data", rsp_rdata, e);
    @(negedge clk);
    chk(!rsp_valid, "R6 single pulse", rsp_valid, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int n;
    int unsigned seed;
    exp_wp   = mx(mx(cyc(55), cyc(60)), mx(cyc(60), cyc(30)));
    exp_rd   = mx(cyc(70), cyc(35));
    exp_turn = cyc(25);
    exp_wc   = cyc(70);
    exp_wake = cyc(70);
    for (int i = 0; i < 1024; i++) begin mem[i] = 16'h0; refm[i] = 16'h0; end
    seed = 32'd20240611;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready, "R11 ready", req_ready, 1);
    chk(sram_ce_n && !sram_ce, "R11 R2 deselected", {sram_ce_n, sram_ce}, 2'b10);
    chk(sram_we_n && sram_oe_n, "R11 strobes high", {sram_we_n, sram_oe_n}, 2'b11);
    chk(!dq_oe && !rsp_valid, "R11 bus released", {dq_oe, rsp_valid}, 0);

    // Directed byte-lane writes and reads (R5)
    do_write(18'd5, 16'hAAAA, 2'b11);
    do_write(18'd5, 16'h1234, 2'b01);
    do_read (18'd5, 2'b11);
    do_write(18'd5, 16'h5678, 2'b10);
    do_read (18'd5, 2'b11);
    do_write(18'd5, 16'hFFFF, 2'b00);
    do_read (18'd5, 2'b11);
    do_read (18'd5, 2'b01);
    do_read (18'd5, 2'b10);
    do_read (18'd5, 2'b00);
    // Read immediately followed by write: turnaround (R7)
    do_read (18'd5, 2'b11);
    do_write(18'd6, 16'hBEEF, 2'b11);
    do_read (18'd6, 2'b11);

    // Standby entry and wake (R9, R10)
    while (!req_ready) @(negedge clk);
    standby_req = 1;
    @(negedge clk);
    chk(!req_ready, "R9 ready low in standby", req_ready, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(sram_ce_n && !sram_ce && !req_ready, "R9 deselected in standby", {sram_ce_n, sram_ce, req_ready}, 3'b100);
    end
    standby_req = 0;
    n = 0;
    @(negedge clk);
    while (!req_ready && n < 100) begin n++; @(negedge clk); end
    chk(n == exp_wake, "R10 wake interval", n, exp_wake);

    // Request wins over standby in the same cycle (R9)
    standby_req = 1;
    req_valid = 1; req_we = 1; req_addr = 18'd9; req_wdata = 16'hC3C3; req_be = 2'b11;
    @(negedge clk);
    req_valid = 0;
    refm[9] = 16'hC3C3;
    chk(!req_ready, "R1 R9 request taken", req_ready, 0);
    repeat (20) @(negedge clk);
    chk(!req_ready && sram_ce_n, "R9 standby after write", {req_ready, sram_ce_n}, 2'b01);
    standby_req = 0;
    do_read(18'd9, 2'b11);

    // Constrained random mix, back to back
    for (int i = 0; i < 400; i++) begin
      logic [17:0] a;
      a = 18'($urandom % 64);
      if ($urandom % 2) do_write(a, 16'($urandom), 2'($urandom % 4));
      else              do_read(a, 2'($urandom % 4));
    end
    while (!req_ready) @(negedge clk);
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule